// File: doc/BRIEF.md
# Sparse Bit-Block Coordination Encoder

The encoder turns one 8x8 block of binary symbols into a compact serial stream. It suits blocks where ones are sparse. The block arrives as a 64-bit word over a valid/ready handshake and is held in a register while the encoder works on it. Rows are coded in order from 0 to 7, and within each row the columns are examined in order from 0 to 7.

A row with no ones costs a single `0`. Each one in a row is marked by a `1` followed by a field that locates it. The first field in a row holds the absolute column in 3 bits. Each later field holds the gap after the previous one, and its width is the ceiling of log2 of the number of columns still to the right of the previous one. Because of this the fields shrink as the row is used up. A `0` closes a row after its last one. When that last one sits in column 7 the row is already complete, so no closing `0` is sent.

The stream leaves one bit per clock, qualified by a bit-valid strobe. A done pulse marks the final bit of row 7.

Top module: `bpc_coord_enc`

## Requirements
- R1: After reset the encoder is idle: `in_ready_o` is 1, and `bit_valid_o` and `done_o` are 0.
- R2: A block is captured only on a cycle where `in_valid_i` and `in_ready_o` are both 1. While an encode is in progress, `in_ready_o` is 0, and changes on `in_block_i` or `in_valid_i` have no effect on the stream.
- R3: Row r, column c of the block is input bit `r*8+c`. Rows are coded in order 0 to 7, and columns are examined in order 0 to 7.
- R4: A row with no ones produces exactly one bit, `0`.
- R5: Each one in a row produces a prefix bit `1`, followed by its position field sent MSB first.
- R6: The first field in a row is 3 bits wide and carries the absolute column of the first one.
- R7: A later field, whose previous one is at column p, is ceil(log2(7-p)) bits wide and carries (column − p − 1). When p is 6 the field is empty and only the prefix `1` is sent. For example, ones at columns 3, 5 and 6 give `1 011 1 01 1 0 0`.
- R8: A single `0` follows the last one of a row, unless that one is in column 7, in which case no closing bit is sent. For example, ones at columns 6 and 7 give `1 110 1`.
- R9: The first stream bit appears in the cycle after acceptance. From then on `bit_valid_o` stays 1 on every cycle, carrying one bit per cycle, up to and including the final bit.
- R10: `done_o` is 1 only together with the final bit of row 7. In the following cycle `in_ready_o` is 1 and `bit_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Block offered |
| in_block_i | input | 64 | Block symbols, row r column c at bit r*8+c |
| in_ready_o | output | 1 | Encoder idle, block can be taken |
| bit_o | output | 1 | Serial stream bit |
| bit_valid_o | output | 1 | `bit_o` carries a stream bit this cycle |
| done_o | output | 1 | Final bit of the block |

## Verification
The embedded properties make no demand on the input side. The block is sampled only at acceptance, so `in_valid_i` may be held or toggled freely and `in_block_i` may change at any time during an encode. The bench exploits this: after every acceptance it drives the inverted block onto the input for the whole encode, so any late sampling corrupts the stream. The bench accepts one bit per cycle with no backpressure, because the stream interface has none. Stimulus covers empty, single-one, end-of-row, dense and pseudo-random blocks, each compared against a software model of the code.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FIELD
  } enc_state_e;

  // smallest w with 2**w >= x, searched up to max_w
  function automatic int unsigned span_bits(int unsigned x, int unsigned max_w);
    int unsigned w;
    w = 0;
    for (int unsigned k = 0; k <= max_w; k++) begin
      if ((32'd1 << k) < x) w = k + 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/bpc_next_one.sv
module bpc_next_one #(
  parameter int COLS  = 8,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic [COLS-1:0]  row_i,
  input  logic [COL_W-1:0] start_i,
  output logic             found_o,
  output logic [COL_W-1:0] pos_o
);

  logic [COLS-1:0] cand;

  for (genvar g = 0; g < COLS; g++) begin : g_cand
    assign cand[g] = row_i[g] & (COL_W'(g) >= start_i);
  end

  // lowest candidate wins
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (cand[c]) begin
        found_o = 1'b1;
        pos_o   = COL_W'(c);
      end
    end
  end

endmodule

// File: rtl/bpc_field_gen.sv
module bpc_field_gen #(
  parameter int COLS  = 8,
  parameter int COL_W = $clog2(COLS),
  parameter int FW_W  = $clog2(COL_W + 1)
) (
  input  logic             first_i,
  input  logic [COL_W-1:0] prev_i,
  input  logic [COL_W-1:0] pos_i,
  output logic [FW_W-1:0]  width_o,
  output logic [COL_W-1:0] value_o
);
  import bpc_pkg::*;

  localparam int SPW = COL_W + 1;
  localparam logic [SPW-1:0] LAST_COL = SPW'(COLS - 1);

  logic [SPW-1:0] span;

  always_comb begin
    span    = first_i ? LAST_COL : LAST_COL - {1'b0, prev_i};
    width_o = FW_W'(span_bits(32'(span), COL_W));
    value_o = first_i ? pos_i : pos_i - prev_i - 1'b1;
  end

endmodule

// File: rtl/bpc_coord_enc.sv
module bpc_coord_enc #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [ROWS*COLS-1:0] in_block_i,
  output logic                 in_ready_o,
  output logic                 bit_o,
  output logic                 bit_valid_o,
  output logic                 done_o
);
  import bpc_pkg::*;

  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int FW_W  = $clog2(COL_W + 1);
  localparam int BLK_W = ROWS * COLS;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  enc_state_e       state_q;
  logic [BLK_W-1:0] blk_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] prev_q;
  logic             first_q;
  logic [FW_W-1:0]  cnt_q;
  logic [COL_W-1:0] val_q;

  logic [COLS-1:0]  rows [ROWS];
  logic [COLS-1:0]  row_bits;
  logic [COL_W-1:0] start;
  logic             found;
  logic [COL_W-1:0] pos;
  logic [FW_W-1:0]  fw;
  logic [COL_W-1:0] fv;
  logic [COL_W-1:0] val_sh;
  logic             row_end;
  logic             last_row;

  for (genvar g = 0; g < ROWS; g++) begin : g_rows
    assign rows[g] = blk_q[g*COLS +: COLS];
  end

  assign row_bits = rows[row_q];
  assign start    = first_q ? '0 : prev_q + 1'b1;
  assign last_row = (row_q == LAST_ROW);

  bpc_next_one #(.COLS(COLS), .COL_W(COL_W)) u_find (
    .row_i   (row_bits),
    .start_i (start),
    .found_o (found),
    .pos_o   (pos)
  );

  bpc_field_gen #(.COLS(COLS), .COL_W(COL_W), .FW_W(FW_W)) u_field (
    .first_i (first_q),
    .prev_i  (prev_q),
    .pos_i   (pos),
    .width_o (fw),
    .value_o (fv)
  );

  assign val_sh = val_q >> (cnt_q - 1'b1);

  always_comb begin
    bit_o   = 1'b0;
    row_end = 1'b0;
    unique case (state_q)
      ST_SCAN: begin
        bit_o   = found;
        row_end = !found || (fw == '0);
      end
      ST_FIELD: begin
        bit_o   = val_sh[0];
        row_end = (cnt_q == FW_W'(1)) && (prev_q == LAST_COL);
      end
      default: ;
    endcase
  end

  assign in_ready_o  = (state_q == ST_IDLE);
  assign bit_valid_o = (state_q != ST_IDLE);
  assign done_o      = bit_valid_o && row_end && last_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      row_q   <= '0;
      prev_q  <= '0;
      first_q <= 1'b1;
      cnt_q   <= '0;
      val_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid_i) begin
            blk_q   <= in_block_i;
            row_q   <= '0;
            first_q <= 1'b1;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (found) begin
            prev_q  <= pos;
            first_q <= 1'b0;
            if (fw != '0) begin
              cnt_q   <= fw;
              val_q   <= fv;
              state_q <= ST_FIELD;
            end
          end
        end
        ST_FIELD: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == FW_W'(1)) state_q <= ST_SCAN;
        end
        default: state_q <= ST_IDLE;
      endcase
      // row advance overrides the per-state next state
      if (bit_valid_o && row_end) begin
        if (last_row) begin
          state_q <= ST_IDLE;
        end else begin
          row_q   <= row_q + 1'b1;
          first_q <= 1'b1;
          state_q <= ST_SCAN;
        end
      end
    end
  end

  // R2: held block never changes during an encode
  a_r2_hold_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(blk_q));

  // R4: empty row emits a single zero
  a_r4_empty_row_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && first_q && row_bits == '0) |-> (!bit_o && done_o == last_row));

  // R7: the field value fits the computed width
  a_r7_field_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && found) |-> ((fv >> fw) == '0));

  // R8: a row never looks for more ones after column 7
  a_r8_no_scan_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == ST_SCAN && !first_q && prev_q == LAST_COL));

  // R9: busy means a bit every cycle
  a_r9_busy_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> bit_valid_o);

  // R10: done rides on a valid bit and returns to idle
  a_r10_done_with_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bit_valid_o);
  a_r10_done_then_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (in_ready_o && !bit_valid_o));

endmodule

// File: tb/bpc_coord_enc_tb.sv
module bpc_coord_enc_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_block;
  logic        in_ready;
  logic        bit_s;
  logic        bit_valid;
  logic        done;

  int n_chk;
  int n_fail;
  logic exp_bits [0:1023];
  int   exp_len;

  bpc_coord_enc dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_block_i  (in_block),
    .in_ready_o  (in_ready),
    .bit_o       (bit_s),
    .bit_valid_o (bit_valid),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clog2i(input int x);
    int w;
    w = 0;
    while ((1 << w) < x) w++;
    return w;
  endfunction

  task automatic push(input logic b);
    exp_bits[exp_len] = b;
    exp_len++;
  endtask

  // software model of the row code
  task automatic build(input logic [63:0] b);
    exp_len = 0;
    for (int r = 0; r < 8; r++) begin
      int prev;
      int last;
      bit first;
      prev = 0; last = -1; first = 1'b1;
      for (int c = 0; c < 8; c++) begin
        if (b[r*8+c]) begin
          int w;
          int v;
          push(1'b1);
          w = first ? 3 : clog2i(7 - prev);
          v = first ? c : c - prev - 1;
          for (int k = w - 1; k >= 0; k--) push(logic'((v >> k) & 1));
          prev = c; last = c; first = 1'b0;
        end
      end
      if (last != 7) push(1'b0);
    end
  endtask

  // offer a block, scramble the input while busy, compare the stream
  task automatic run_block(input logic [63:0] b, input string req, input int want_len);
    int idx;
    build(b);
    if (want_len >= 0) chk(exp_len == want_len, req, exp_len, want_len);
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
    in_valid = 1'b1;
    in_block = b;
    @(negedge clk);
    in_block = ~b;
    in_valid = 1'b1;  // R2: held valid while busy is ignored
    chk(in_ready == 1'b0, "R2", int'(in_ready), 0);
    idx = 0;
    forever begin
      chk(bit_valid == 1'b1, "R9", int'(bit_valid), 1);
      if (!bit_valid) break;
      chk(bit_s == exp_bits[idx], req, int'(bit_s), int'(exp_bits[idx]));
      chk(done == (idx == exp_len - 1), "R10", int'(done), int'(idx == exp_len - 1));
      if (done || idx >= exp_len - 1) break;
      idx++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && bit_valid == 1'b0, "R10", int'({in_ready, bit_valid}), 2);
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(bit_valid == 1'b0, "R1", int'(bit_valid), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
  endtask

  task automatic t_empty;
    run_block(64'h0, "R4", 8);
  endtask

  task automatic t_gap_fields;
    run_block(64'h0000_0000_0000_0068, "R7", 17);  // row0 cols 3,5,6
    run_block(64'h0000_0000_6800_0000, "R7", 17);  // row3 same pattern
  endtask

  task automatic t_row_tail;
    run_block(64'h0000_0000_0000_00C0, "R8", 12);  // row0 cols 6,7
    run_block(64'h0000_8000_0000_0000, "R8", 11);  // row5 col 7 only
    run_block(64'h0000_0000_0000_00A0, "R8", 13);  // row0 cols 5,7
  endtask

  task automatic t_first_field;
    run_block(64'h0100_0000_0000_0000, "R6", 12);  // row7 col 0
    run_block(64'h0000_0000_0010_0000, "R6", 12);  // row2 col 4
  endtask

  task automatic t_dense;
    run_block(64'h0000_0000_FF00_0000, "R5", -1);
    run_block(64'hFFFF_FFFF_FFFF_FFFF, "R3", -1);
    run_block(64'h8040_2010_0804_0201, "R3", -1);
  endtask

  task automatic t_random;
    logic [63:0] s;
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 24; n++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 7);
      s = s ^ (s << 17);
      run_block((n % 3 == 0) ? (s & (s >> 5) & (s >> 9)) : s, "R3", -1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_block = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_empty;
    t_gap_fields;
    t_row_tail;
    t_first_field;
    t_dense;
    t_random;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule